// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm

This peripheral keeps time from a slow clock (nominally 32768 Hz) and presents its state on a register port that runs on a fast bus clock. A programmable prescaler divides the slow clock. Each time the prescaler completes a count, a wrapping real-time counter advances by one. An alarm register holds an absolute counter value, and a match against it raises an event. A separate interval timer counts raw slow-clock cycles and raises an event at the end of every programmed period.

Events from the slow domain cross into the bus domain through toggle synchronizers and set sticky status bits there. A status read returns the pending bits and clears them. Software turns interrupt enables on and off through separate write-one-to-set and write-one-to-clear registers. The block drives one interrupt line, which is the OR of all pending status bits that are enabled.

The counter reaches the bus through a Gray-code synchronizer, so every read returns a value the counter really held. Configuration writes go to the slow domain through a toggle handshake. While a handshake is in flight, the port holds its ready signal low.

Top module: `sct_timer`

## Requirements
- R1: The counter is CNT_W bits wide (20 by default). It advances by exactly one per prescaler period and wraps from all ones to zero.
- R2: The prescaler at 0x14 sets the number of slow cycles per counter step. The value N gives N cycles, the value 0 gives 65536, and the reset value 32768 gives one step per second. Writing the prescaler restarts its divider from zero.
- R3: The alarm at 0x18 sets status bit 3 only on the step that makes the counter equal to the alarm value. If the alarm is written with the counter's current value, it does not fire until the counter has gone all the way around.
- R4: The interval timer sets status bit 0 once every P slow cycles, where P is the period at 0x10 (0 gives 65536). Writing the period restarts the interval.
- R5: Every counter step sets status bit 2. Status bit 1 (watchdog overflow) always reads 0.
- R6: A read of status at 0x00 returns the pending bits and clears them. A bit whose event arrives in the same cycle as the read stays set for the next read.
- R7: Writing ones to 0x04 sets enable bits, and writing ones to 0x08 clears them. Bits written as zero keep their value. Bit 1 cannot be enabled. The mask reads back at 0x0C and is 0 after reset.
- R8: `irq` is high exactly when a pending status bit is also enabled. It follows a mask or status change one bus cycle later.
- R9: Reads of the counter at 0x1C return values the counter actually held. Back-to-back reads never step backwards.
- R10: A request is taken in a cycle where `req_valid` and `req_ready` are both high. Read data comes back on the next cycle with `rsp_valid`. After a write to 0x10, 0x14 or 0x18, `req_ready` stays low until the slow domain has taken the value. These three registers read back what was written.
- R11: After reset, status, mask, period, alarm and counter are all 0, the prescaler is 32768, `irq` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Slow timekeeping clock |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Combined interrupt |

## Verification
Assertions check on every cycle that the counter only ever steps by one and that the synchronized Gray value changes by at most one bit. They also check that an alarm event leaves the counter equal to the alarm register, and that a status read clears every bit except those arriving in the same cycle. The remaining per-cycle checks cover enable writes setting mask bits, config writes dropping ready, and responses following reads. Only the bench scenarios can show prescaler rates (including the 65536 case), wrap-around, an alarm written at the current count waiting a full revolution, interval timing and the interrupt line following the mask.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int NEVT   = 4;

  localparam logic [ADDR_W-1:0] ADR_STATUS = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_IDIS   = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_PRESC  = 5'h14;
  localparam logic [ADDR_W-1:0] ADR_ALARM  = 5'h18;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 5'h1C;

  // event bit positions in status and mask
  localparam int EV_PERIOD = 0;
  localparam int EV_WDOG   = 1;
  localparam int EV_TICK   = 2;
  localparam int EV_ALARM  = 3;
  localparam logic [NEVT-1:0] EVT_VALID = 4'b1101;

  typedef enum logic [1:0] {
    CFG_PERIOD = 2'd0,
    CFG_PRESC  = 2'd1,
    CFG_ALARM  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/sct_rst_sync.sv
module sct_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/sct_sync.sv
module sct_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sct_slow_core.sv
module sct_slow_core
  import sct_pkg::*;
#(
  parameter int                CNT_W   = 20,
  parameter int                PRE_W   = 16,
  parameter int                PIT_W   = 16,
  parameter logic [PRE_W-1:0]  PRE_RST = 16'h8000
) (
  input  logic             sclk,
  input  logic             srst_n,
  input  logic             cfg_tgl,
  input  cfg_sel_e         cfg_sel,
  input  logic [PIT_W-1:0] cfg_period,
  input  logic [PRE_W-1:0] cfg_presc,
  input  logic [CNT_W-1:0] cfg_alarm,
  output logic             cfg_ack,
  output logic [NEVT-1:0]  evt_tgl,
  output logic [CNT_W-1:0] cnt_gray
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;
  localparam logic [PIT_W-1:0] PIT_ONE = 1;

  logic             tgl_s, tgl_prev_q, cfg_edge;
  logic [PRE_W-1:0] presc_s, presc_d, div_q, div_d;
  logic [PIT_W-1:0] period_s, period_d, pit_q, pit_d;
  logic [CNT_W-1:0] alarm_s, alarm_d, cnt_q, cnt_d, gray_d;
  logic [NEVT-1:0]  evt_q, evt_d;
  logic             tick, pit_hit, alm_hit, cfg_en;

  sct_sync #(.W(1)) u_cfg_sync (
    .clk(sclk), .rst_n(srst_n), .d(cfg_tgl), .q(tgl_s)
  );

  always_comb begin
    cfg_edge = tgl_s ^ tgl_prev_q;
    cfg_en   = cfg_edge;
    presc_d  = presc_s;
    period_d = period_s;
    alarm_d  = alarm_s;
    tick     = (div_q == presc_s - PRE_ONE);
    div_d    = tick ? '0 : div_q + PRE_ONE;
    pit_hit  = (pit_q == period_s - PIT_ONE);
    pit_d    = pit_hit ? '0 : pit_q + PIT_ONE;
    if (cfg_edge) begin
      case (cfg_sel)
        CFG_PERIOD: begin
          period_d = cfg_period;
          pit_d    = '0;
          pit_hit  = 1'b0;
        end
        CFG_PRESC: begin
          presc_d = cfg_presc;
          div_d   = '0;
          tick    = 1'b0;
        end
        CFG_ALARM: alarm_d = cfg_alarm;
        default: ;
      endcase
    end
    cnt_d   = tick ? cnt_q + CNT_ONE : cnt_q;
    alm_hit = tick && (cnt_d == alarm_s);
    evt_d   = evt_q;
    evt_d[EV_PERIOD] = evt_q[EV_PERIOD] ^ pit_hit;
    evt_d[EV_TICK]   = evt_q[EV_TICK] ^ tick;
    evt_d[EV_ALARM]  = evt_q[EV_ALARM] ^ alm_hit;
    gray_d  = cnt_d ^ (cnt_d >> 1);
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      tgl_prev_q <= 1'b0;
      presc_s    <= PRE_RST;
      period_s   <= '0;
      alarm_s    <= '0;
      div_q      <= '0;
      pit_q      <= '0;
      cnt_q      <= '0;
      evt_q      <= '0;
      cnt_gray   <= '0;
    end else begin
      tgl_prev_q <= tgl_s;
      if (cfg_en) begin
        presc_s  <= presc_d;
        period_s <= period_d;
        alarm_s  <= alarm_d;
      end
      div_q <= div_d;
      pit_q <= pit_d;
      if (tick) cnt_q <= cnt_d;
      evt_q    <= evt_d;
      cnt_gray <= gray_d;
    end
  end

  assign cfg_ack = tgl_prev_q;
  assign evt_tgl = evt_q;

  // R1: the counter never jumps, it only steps by one (wrapping)
  a_r1_count_step: assert property (@(posedge sclk) disable iff (!srst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_ONE))
    else $error("counter moved by more than one");

  // R3: an alarm event leaves the counter on the alarm value
  a_r3_alarm_lands: assert property (@(posedge sclk) disable iff (!srst_n)
    alm_hit |=> (cnt_q == $past(alarm_s)))
    else $error("alarm fired off its match value");
endmodule

// File: rtl/sct_bus_regs.sv
module sct_bus_regs
  import sct_pkg::*;
#(
  parameter int               CNT_W   = 20,
  parameter int               PRE_W   = 16,
  parameter int               PIT_W   = 16,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq,
  input  logic [NEVT-1:0]   evt_tgl,
  input  logic [CNT_W-1:0]  cnt_gray,
  input  logic              cfg_ack,
  output logic              cfg_tgl,
  output cfg_sel_e          cfg_sel,
  output logic [PIT_W-1:0]  cfg_period,
  output logic [PRE_W-1:0]  cfg_presc,
  output logic [CNT_W-1:0]  cfg_alarm
);
  logic [NEVT-1:0]   evt_s, evt_prev_q, evt_pulse;
  logic [CNT_W-1:0]  gray_s, cnt_bin;
  logic              ack_s, pending;
  logic              acc, wr_acc, rd_acc, sts_rd;
  logic [NEVT-1:0]   sts_q, sts_d, msk_q, msk_d;
  logic              irq_d, tgl_d;
  cfg_sel_e          sel_d;
  logic [PIT_W-1:0]  period_d;
  logic [PRE_W-1:0]  presc_d;
  logic [CNT_W-1:0]  alarm_d;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_bits;

  sct_sync #(.W(NEVT))  u_evt_sync (.clk(clk), .rst_n(rst_n), .d(evt_tgl),  .q(evt_s));
  sct_sync #(.W(CNT_W)) u_cnt_sync (.clk(clk), .rst_n(rst_n), .d(cnt_gray), .q(gray_s));
  sct_sync #(.W(1))     u_ack_sync (.clk(clk), .rst_n(rst_n), .d(cfg_ack),  .q(ack_s));

  assign unused_bits = ^req_wdata;

  always_comb begin
    cnt_bin[CNT_W-1] = gray_s[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) cnt_bin[i] = cnt_bin[i+1] ^ gray_s[i];
  end

  always_comb begin
    pending   = cfg_tgl ^ ack_s;
    req_ready = !pending;
    acc       = req_valid && req_ready;
    wr_acc    = acc && req_write;
    rd_acc    = acc && !req_write;
    sts_rd    = rd_acc && (req_addr == ADR_STATUS);
    evt_pulse = evt_s ^ evt_prev_q;
    sts_d     = (sts_rd ? '0 : sts_q) | (evt_pulse & EVT_VALID);
    msk_d     = msk_q;
    tgl_d     = cfg_tgl;
    sel_d     = cfg_sel;
    period_d  = cfg_period;
    presc_d   = cfg_presc;
    alarm_d   = cfg_alarm;
    if (wr_acc) begin
      case (req_addr)
        ADR_IEN:    msk_d = msk_q | (req_wdata[NEVT-1:0] & EVT_VALID);
        ADR_IDIS:   msk_d = msk_q & ~req_wdata[NEVT-1:0];
        ADR_PERIOD: begin period_d = req_wdata[PIT_W-1:0]; sel_d = CFG_PERIOD; tgl_d = ~cfg_tgl; end
        ADR_PRESC:  begin presc_d  = req_wdata[PRE_W-1:0]; sel_d = CFG_PRESC;  tgl_d = ~cfg_tgl; end
        ADR_ALARM:  begin alarm_d  = req_wdata[CNT_W-1:0]; sel_d = CFG_ALARM;  tgl_d = ~cfg_tgl; end
        default: ;
      endcase
    end
    irq_d   = |(sts_d & msk_d);
    rdata_d = '0;
    case (req_addr)
      ADR_STATUS: rdata_d[NEVT-1:0]  = sts_q;
      ADR_MASK:   rdata_d[NEVT-1:0]  = msk_q;
      ADR_PERIOD: rdata_d[PIT_W-1:0] = cfg_period;
      ADR_PRESC:  rdata_d[PRE_W-1:0] = cfg_presc;
      ADR_ALARM:  rdata_d[CNT_W-1:0] = cfg_alarm;
      ADR_COUNT:  rdata_d[CNT_W-1:0] = cnt_bin;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev_q <= '0;
      sts_q      <= '0;
      msk_q      <= '0;
      irq        <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      cfg_tgl    <= 1'b0;
      cfg_sel    <= CFG_PERIOD;
      cfg_period <= '0;
      cfg_presc  <= PRE_RST;
      cfg_alarm  <= '0;
    end else begin
      evt_prev_q <= evt_s;
      sts_q      <= sts_d;
      msk_q      <= msk_d;
      irq        <= irq_d;
      rsp_valid  <= rd_acc;
      if (rd_acc) rsp_rdata <= rdata_d;
      if (wr_acc) begin
        cfg_tgl    <= tgl_d;
        cfg_sel    <= sel_d;
        cfg_period <= period_d;
        cfg_presc  <= presc_d;
        cfg_alarm  <= alarm_d;
      end
    end
  end

  // R6: a status read with no arriving event leaves nothing pending
  a_r6_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && ((evt_pulse & EVT_VALID) == '0)) |=> (sts_q == '0))
    else $error("status not cleared by read");

  // R6: an arriving event is never lost, even during a status read
  a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_pulse & EVT_VALID) != '0) |=> ((sts_q & $past(evt_pulse & EVT_VALID)) == $past(evt_pulse & EVT_VALID)))
    else $error("status event lost");

  // R7: write-one-to-set enables
  a_r7_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADR_IEN) |=> ((msk_q & $past(req_wdata[NEVT-1:0] & EVT_VALID)) == $past(req_wdata[NEVT-1:0] & EVT_VALID)))
    else $error("enable write lost");

  // R9: the synchronized count changes by at most one bit per cycle
  a_r9_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_s ^ $past(gray_s)) <= 1)
    else $error("count crossing not single-bit");

  // R10: responses follow reads, and config writes hold off the port
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid)
    else $error("read without response");
  a_r10_cfg_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (req_addr == ADR_PERIOD || req_addr == ADR_PRESC || req_addr == ADR_ALARM)) |=> !req_ready)
    else $error("config write did not stall port");
endmodule

// File: rtl/sct_timer.sv
module sct_timer
  import sct_pkg::*;
#(
  parameter int               CNT_W   = 20,
  parameter int               PRE_W   = 16,
  parameter int               PIT_W   = 16,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_clk,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        irq
);
  logic             brst_n, srst_n;
  logic             cfg_tgl, cfg_ack;
  cfg_sel_e         cfg_sel;
  logic [PIT_W-1:0] cfg_period;
  logic [PRE_W-1:0] cfg_presc;
  logic [CNT_W-1:0] cfg_alarm, cnt_gray;
  logic [NEVT-1:0]  evt_tgl;

  sct_rst_sync u_rst_bus  (.clk(clk),      .arst_n(rst_n), .srst_n(brst_n));
  sct_rst_sync u_rst_slow (.clk(slow_clk), .arst_n(rst_n), .srst_n(srst_n));

  sct_slow_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PIT_W(PIT_W), .PRE_RST(PRE_RST)) u_core (
    .sclk(slow_clk), .srst_n(srst_n), .cfg_tgl(cfg_tgl), .cfg_sel(cfg_sel),
    .cfg_period(cfg_period), .cfg_presc(cfg_presc), .cfg_alarm(cfg_alarm),
    .cfg_ack(cfg_ack), .evt_tgl(evt_tgl), .cnt_gray(cnt_gray)
  );

  sct_bus_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PIT_W(PIT_W), .PRE_RST(PRE_RST)) u_regs (
    .clk(clk), .rst_n(brst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq),
    .evt_tgl(evt_tgl), .cnt_gray(cnt_gray), .cfg_ack(cfg_ack), .cfg_tgl(cfg_tgl),
    .cfg_sel(cfg_sel), .cfg_period(cfg_period), .cfg_presc(cfg_presc), .cfg_alarm(cfg_alarm)
  );
endmodule

// File: tb/sct_timer_tb_top.sv
module sct_timer_tb_top;
  localparam int CW = 12;
  localparam logic [4:0] A_STS = 5'h00, A_IEN = 5'h04, A_IDIS = 5'h08, A_MSK = 5'h0C,
                         A_PER = 5'h10, A_PRE = 5'h14, A_ALM = 5'h18, A_CNT = 5'h1C;

  logic clk, sclk, rst_n;
  logic req_valid, req_ready, req_write, rsp_valid, irq;
  logic [4:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata, last_rd;
  int n_cmp, n_bad;
  bit done;

  typedef struct {
    bit          chk;
    logic [31:0] msk;
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } item_t;
  item_t sb_q[$];
  item_t it;

  sct_timer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk(sclk), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  initial sclk = 1'b0;
  always #50 sclk = ~sclk;

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        it = sb_q.pop_front();
        last_rd = rsp_rdata;
        if (it.chk) begin
          n_cmp++;
          if (((rsp_rdata & it.msk) < it.lo) || ((rsp_rdata & it.msk) > it.hi)) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h..%h", it.tag, rsp_rdata & it.msk, it.lo, it.hi);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    bus_op(1'b1, a, d);
  endtask

  // R10: config write must stall the port right after it is taken
  task automatic wr_cfg(input logic [4:0] a, input logic [31:0] d);
    bus_op(1'b1, a, d);
    chk(req_ready == 1'b0, "R10 ready low after config write", {31'd0, req_ready}, 32'd0);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] m, input logic [31:0] lo,
                        input logic [31:0] hi, input string tag);
    item_t e;
    e.chk = 1'b1; e.msk = m; e.lo = lo; e.hi = hi; e.tag = tag;
    sb_q.push_back(e);
    bus_op(1'b0, a, 32'd0);
  endtask

  task automatic rd_get(input logic [4:0] a, output logic [31:0] v);
    item_t e;
    e.chk = 1'b0; e.msk = '1; e.lo = '0; e.hi = '1; e.tag = "";
    sb_q.push_back(e);
    bus_op(1'b0, a, 32'd0);
    @(posedge clk);
    v = last_rd;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge sclk);
    @(negedge clk);
  endtask

  function automatic logic [CW-1:0] dif(input logic [31:0] a, input logic [31:0] b);
    return b[CW-1:0] - a[CW-1:0];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] a, b, v, prev;
    int ones, wraps;
    bit okstep;
    done = 1'b0; n_cmp = 0; n_bad = 0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    #200 rst_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);

    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(irq == 1'b0, "R11 irq after reset", {31'd0, irq}, 32'd0);
    rd_chk(A_STS, '1, 0, 0, "R11 status reset");
    rd_chk(A_MSK, '1, 0, 0, "R11 mask reset");
    rd_chk(A_PRE, '1, 32'h8000, 32'h8000, "R11 prescaler reset");
    rd_chk(A_PER, '1, 0, 0, "R11 period reset");
    rd_chk(A_ALM, '1, 0, 0, "R11 alarm reset");
    rd_chk(A_CNT, '1, 0, 0, "R11 counter reset");

    // R2 prescaler 0 means 65536: counter frozen over a short window
    wr_cfg(A_PRE, 32'd0);
    rd_chk(A_PRE, '1, 0, 0, "R10 prescaler readback 0");
    wait_slow(10);
    rd_get(A_STS, v);
    rd_chk(A_STS, '1, 0, 0, "R6 status cleared by read");
    rd_chk(A_STS, 32'h2, 0, 0, "R5 watchdog bit reads 0");
    rd_get(A_CNT, a);
    wait_slow(300);
    rd_get(A_CNT, b);
    chk(dif(a, b) == 0, "R2 prescaler 0 is 65536 cycles", {20'd0, dif(a, b)}, 32'd0);

    // R1 prescaler 1: one step per slow cycle
    wr_cfg(A_PRE, 32'd1);
    rd_chk(A_PRE, '1, 1, 1, "R10 prescaler readback 1");
    wait_slow(10);
    rd_get(A_CNT, a);
    wait_slow(50);
    rd_get(A_CNT, b);
    chk(dif(a, b) >= 49 && dif(a, b) <= 52, "R1 rate at prescaler 1", {20'd0, dif(a, b)}, 32'd50);

    // R9 back-to-back reads never step backwards or jump
    okstep = 1'b1;
    rd_get(A_CNT, prev);
    for (int i = 0; i < 20; i++) begin
      rd_get(A_CNT, v);
      if (dif(prev, v) > 2) okstep = 1'b0;
      prev = v;
    end
    chk(okstep, "R9 coherent counter reads", {31'd0, okstep}, 32'd1);
    rd_chk(A_STS, 32'h4, 4, 4, "R5 step sets status bit 2");

    // R2 prescaler 4
    wr_cfg(A_PRE, 32'd4);
    rd_get(A_CNT, a);
    wait_slow(80);
    rd_get(A_CNT, b);
    chk(dif(a, b) >= 19 && dif(a, b) <= 21, "R2 rate at prescaler 4", {20'd0, dif(a, b)}, 32'd20);

    // R7 / R8 mask and interrupt
    wr_cfg(A_PRE, 32'd1);
    wr_reg(A_IEN, 32'h4);
    rd_chk(A_MSK, '1, 4, 4, "R7 enable set");
    wait_slow(5);
    chk(irq == 1'b1, "R8 irq with enabled pending bit", {31'd0, irq}, 32'd1);
    wr_reg(A_IDIS, 32'h4);
    chk(irq == 1'b0, "R8 irq drops when disabled", {31'd0, irq}, 32'd0);
    rd_chk(A_MSK, '1, 0, 0, "R7 disable clears");
    wr_reg(A_IEN, 32'h9);
    wr_reg(A_IDIS, 32'h1);
    rd_chk(A_MSK, '1, 8, 8, "R7 zero bits unchanged");
    wr_reg(A_IEN, 32'h2);
    rd_chk(A_MSK, '1, 8, 8, "R7 bit 1 cannot be enabled");

    // R6 no step lost across back-to-back status reads
    rd_get(A_STS, v);
    rd_get(A_CNT, a);
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      rd_get(A_STS, v);
      if (v[2]) ones++;
    end
    rd_get(A_CNT, b);
    chk((ones + 2 >= int'(dif(a, b))) && (ones <= int'(dif(a, b)) + 2), "R6 events kept across reads",
        ones, {20'd0, dif(a, b)});

    // R3 alarm ahead of the counter
    rd_get(A_CNT, a);
    wr_cfg(A_ALM, (a + 40) & 32'hFFF);
    rd_chk(A_ALM, '1, (a + 40) & 32'hFFF, (a + 40) & 32'hFFF, "R10 alarm readback");
    rd_get(A_STS, v);
    wait_slow(15);
    rd_chk(A_STS, 32'h8, 0, 0, "R3 no alarm before match");
    wait_slow(40);
    chk(irq == 1'b1, "R8 irq on enabled alarm", {31'd0, irq}, 32'd1);
    rd_chk(A_STS, 32'h8, 8, 8, "R3 alarm on match");
    chk(irq == 1'b0, "R8 irq clears with status read", {31'd0, irq}, 32'd0);

    // R1 wrap: sample around the whole range
    wraps = 0; okstep = 1'b1;
    rd_get(A_CNT, prev);
    for (int i = 0; i < 66; i++) begin
      wait_slow(64);
      rd_get(A_CNT, v);
      if (dif(prev, v) < 64 || dif(prev, v) > 66) okstep = 1'b0;
      if (v[CW-1:0] < prev[CW-1:0]) wraps++;
      prev = v;
    end
    chk(okstep, "R1 steady steps across range", {31'd0, okstep}, 32'd1);
    chk(wraps >= 1, "R1 counter wraps to zero", wraps, 32'd1);

    // R3 alarm written with the current count waits a full revolution
    wr_cfg(A_PRE, 32'd0);
    wait_slow(6);
    rd_get(A_CNT, a);
    wr_cfg(A_ALM, a);
    wr_cfg(A_PRE, 32'd1);
    rd_get(A_STS, v);
    wait_slow(3900);
    rd_chk(A_STS, 32'h8, 0, 0, "R3 no match before full revolution");
    wait_slow(250);
    rd_chk(A_STS, 32'h8, 8, 8, "R3 match after full revolution");

    // R4 interval timer
    wr_cfg(A_PRE, 32'd0);
    wr_cfg(A_PER, 32'd40);
    rd_chk(A_PER, '1, 40, 40, "R10 period readback");
    rd_get(A_STS, v);
    wait_slow(25);
    rd_chk(A_STS, 32'h1, 0, 0, "R4 no expiry before period");
    wait_slow(25);
    rd_chk(A_STS, 32'h1, 1, 1, "R4 expiry after period");
    wait_slow(45);
    rd_chk(A_STS, 32'h1, 1, 1, "R4 expiry repeats");

    repeat (5) @(posedge clk);
    chk(sb_q.size() == 0, "R10 all reads answered", sb_q.size(), 32'd0);
    finish_run();
  end
endmodule